// File: doc/BRIEF.md
# Byte-String Move and Compare Engine

This engine runs a storage-to-storage byte-string operation between two operands in a byte-wide memory. The memory has one port. A caller presents an operation code, an 8-bit length code and two 24-bit starting addresses, then raises `start` for one cycle. The engine then works through the operands one byte at a time, from the lowest address upward, and raises `done` for one cycle when it has finished.

A move copies bytes from the second operand into the first. Each byte is read from the source and written to the destination before the next byte is read. When the destination starts one byte above the source, the first byte therefore spreads across the whole destination. A compare reads both operands and stops at the first pair of bytes that differ. It reports the result as a 2-bit condition code. The first operand's length governs both operands. The length code is one less than the byte count, so no operation has zero length.

Top module: `ss_char_engine`

## Requirements
- R1: After reset, `busy`, `done`, `memRd` and `memWr` are low and `condCode` is 0.
- R2: Operation code 0xD2 copies operand 2 (at `srcAddr`) into operand 1 (at `dstAddr`). Bytes go in ascending address order and never touch memory outside operand 1.
- R3: The byte count is `lenCode` + 1. Code 0x00 processes 1 byte, 0x0D processes 14 bytes and 0xFF processes 256 bytes.
- R4: In a move, each byte takes a read cycle of `srcAddr`+i and then a write cycle of `dstAddr`+i. The written data is the read data returned one cycle after the read. `done` rises 2·N+1 cycles after the start edge, where N is the byte count.
- R5: Operation code 0xD5 compares without writing. `condCode` is 0 when all bytes are equal. At the first differing byte, using an unsigned comparison, it is 1 when operand 1 is lower and 2 when operand 1 is higher. Value 3 never occurs.
- R6: A compare stops at the first differing byte at index k: it makes exactly 2·(k+1) reads, and `done` rises 3·(k+1)+1 cycles after the start edge.
- R7: A move whose destination begins one byte above its source fills the whole destination with the source's first byte.
- R8: `start` is ignored while `busy` is high, including the `done` cycle. It does not change the running operation, and it does not begin a new one.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after the start edge through the `done` cycle.
- R10: An accepted start clears `condCode`. The value from a compare holds until the next accepted start, so a move leaves it at 0.
- R11: Any other operation code makes no memory access and finishes with `done` one cycle after the start edge, with `condCode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opCode | input | 8 | 0xD2 move, 0xD5 compare |
| lenCode | input | 8 | Byte count minus one |
| dstAddr | input | 24 | Operand 1 start address |
| srcAddr | input | 24 | Operand 2 start address |
| memAddr | output | 24 | Memory byte address |
| memRd | output | 1 | Memory read enable |
| memWr | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Read data, valid the cycle after `memRd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| condCode | output | 2 | Compare result |

## Verification
A wrong byte index or a wrong operand select shows up as a corrupted or missing memory byte at the end of the operation. It also shows up as an address outside the operand range during the operation itself. A wrong state transition changes the number of reads and writes and the cycle at which `done` rises, so it is caught within the operation where it happens. A compare that fails to stop early, or that orders bytes as signed values, gives a wrong read count or condition code at the `done` pulse.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;
  localparam logic [7:0] OPC_MOVE = 8'hD2;
  localparam logic [7:0] OPC_CMP  = 8'hD5;

  localparam logic [1:0] CC_EQ   = 2'd0;
  localparam logic [1:0] CC_LOW  = 2'd1;
  localparam logic [1:0] CC_HIGH = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MV_RD,
    ST_MV_WR,
    ST_CP_RD1,
    ST_CP_RD2,
    ST_CP_EVAL,
    ST_FIN
  } engState_t;

  typedef struct packed {
    logic load;     // capture operands, clear index
    logic advance;  // step to next byte
    logic selSrc;   // address operand 2 instead of operand 1
    logic holdA;    // keep operand 1 byte
    logic setCc;    // record compare outcome
    logic clrCc;    // clear condition code
  } dpStrobe_t;
endpackage

// File: rtl/ss_dpath.sv
`timescale 1ns/1ps
module ss_dpath
  import ss_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              isLast,
  output logic              differ,
  output logic [1:0]        condCode
);
  localparam int IDX_PAD = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] dstQ, srcQ;
  logic [LEN_W-1:0]  lenQ, idxQ;
  logic [DATA_W-1:0] holdQ;
  logic [1:0]        ccQ;
  logic [ADDR_W-1:0] idxWide;

  assign idxWide  = {{IDX_PAD{1'b0}}, idxQ};
  assign memAddr  = (strobe.selSrc ? srcQ : dstQ) + idxWide;
  assign memWdata = memRdata;
  assign isLast   = (idxQ == lenQ);
  assign differ   = (holdQ != memRdata);
  assign condCode = ccQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ  <= '0;
      srcQ  <= '0;
      lenQ  <= '0;
      idxQ  <= '0;
      holdQ <= '0;
      ccQ   <= CC_EQ;
    end else begin
      if (strobe.load) begin
        dstQ <= dstIn;
        srcQ <= srcIn;
        lenQ <= lenIn;
        idxQ <= '0;
      end else if (strobe.advance) begin
        idxQ <= idxQ + 1'b1;
      end
      if (strobe.holdA) holdQ <= memRdata;
      if (strobe.clrCc) begin
        ccQ <= CC_EQ;
      end else if (strobe.setCc) begin
        if (!differ)                ccQ <= CC_EQ;
        else if (holdQ < memRdata)  ccQ <= CC_LOW;
        else                        ccQ <= CC_HIGH;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= lenQ); // R3
  AST_CC_ENCODING: assert property (@(posedge clk) disable iff (!rstN)
    ccQ != 2'b11); // R5
  AST_CC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrCc && !strobe.setCc) |=> $stable(ccQ)); // R10
endmodule

// File: rtl/ss_ctrl.sv
`timescale 1ns/1ps
module ss_ctrl
  import ss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opCode,
  input  logic       isLast,
  input  logic       differ,
  output dpStrobe_t  strobe,
  output logic       memRd,
  output logic       memWr,
  output logic       busy,
  output logic       done
);
  engState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    memRd  = 1'b0;
    memWr  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load  = 1'b1;
          strobe.clrCc = 1'b1;
          if (opCode == OPC_MOVE)     stateD = ST_MV_RD;
          else if (opCode == OPC_CMP) stateD = ST_CP_RD1;
          else                        stateD = ST_FIN;
        end
      end
      ST_MV_RD: begin
        memRd         = 1'b1;
        strobe.selSrc = 1'b1;
        stateD        = ST_MV_WR;
      end
      ST_MV_WR: begin
        memWr = 1'b1;
        if (isLast) begin
          stateD = ST_FIN;
        end else begin
          strobe.advance = 1'b1;
          stateD         = ST_MV_RD;
        end
      end
      ST_CP_RD1: begin
        memRd  = 1'b1;
        stateD = ST_CP_RD2;
      end
      ST_CP_RD2: begin
        memRd         = 1'b1;
        strobe.selSrc = 1'b1;
        strobe.holdA  = 1'b1;
        stateD        = ST_CP_EVAL;
      end
      ST_CP_EVAL: begin
        if (differ || isLast) begin
          strobe.setCc = 1'b1;
          stateD       = ST_FIN;
        end else begin
          strobe.advance = 1'b1;
          stateD         = ST_CP_RD1;
        end
      end
      ST_FIN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R8
  AST_RD_BEFORE_WR: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd)); // R4
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R9
endmodule

// File: rtl/ss_char_engine.sv
`timescale 1ns/1ps
module ss_char_engine
  import ss_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opCode,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        condCode
);
  dpStrobe_t strobe;
  logic      isLast;
  logic      differ;

  ss_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opCode (opCode),
    .isLast (isLast),
    .differ (differ),
    .strobe (strobe),
    .memRd  (memRd),
    .memWr  (memWr),
    .busy   (busy),
    .done   (done)
  );

  ss_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dstIn    (dstAddr),
    .srcIn    (srcAddr),
    .lenIn    (lenCode),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .isLast   (isLast),
    .differ   (differ),
    .condCode (condCode)
  );

  AST_WR_DATA_FROM_RD: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memWdata == memRdata)); // R4
  AST_NO_WR_IN_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && $past(!busy) && $past(opCode) == OPC_CMP) |-> !memWr); // R5
endmodule

// File: tb/test_ss_char_engine.sv
`timescale 1ns/1ps
module test_ss_char_engine;
  localparam int MSZ = 1024;
  localparam logic [7:0] MV = 8'hD2;
  localparam logic [7:0] CP = 8'hD5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opCode = '0, lenCode = '0;
  logic [23:0] dstAddr = '0, srcAddr = '0;
  logic [23:0] memAddr;
  logic        memRd, memWr, busy, done;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic [1:0]  condCode;

  logic [7:0] mem [MSZ];
  logic [7:0] refMem [MSZ];
  int nChecks = 0, nFails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ss_char_engine i_ss_char_engine (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .lenCode(lenCode),
    .dstAddr(dstAddr), .srcAddr(srcAddr), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata), .busy(busy),
    .done(done), .condCode(condCode));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRd) memRdata <= mem[memAddr[9:0]];
    if (memWr) mem[memAddr[9:0]] <= memWdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ccOf(input logic [7:0] a, input logic [7:0] b);
    if (a == b) return 2'd0;
    return (a < b) ? 2'd1 : 2'd2;
  endfunction

  function automatic int addrOf(input int base, input int i);
    return (base + i) % MSZ;
  endfunction

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  task automatic runOp(input logic [7:0] op, input int len, input int a1, input int a2,
                       input bit poke, input string tag);
    int n, k, expCyc, expRd, expWr, cnt, rd, wr, diffs;
    logic [1:0] expCc;
    bit gotDone;
    n = len + 1; expCc = 0; expWr = 0;
    if (op == MV) begin
      for (int i = 0; i < n; i++) refMem[addrOf(a1, i)] = refMem[addrOf(a2, i)];
      expCyc = 2 * n + 1; expRd = n; expWr = n;
    end else if (op == CP) begin
      k = len;
      for (int i = 0; i < n; i++)
        if (refMem[addrOf(a1, i)] != refMem[addrOf(a2, i)]) begin k = i; break; end
      expCc = ccOf(refMem[addrOf(a1, k)], refMem[addrOf(a2, k)]);
      expCyc = 3 * (k + 1) + 1; expRd = 2 * (k + 1);
    end else begin
      expCyc = 1; expRd = 0;
    end
    @(negedge clk);
    start = 1'b1; opCode = op; lenCode = 8'(len); dstAddr = 24'(a1); srcAddr = 24'(a2);
    cnt = 0; rd = 0; wr = 0; gotDone = 0;
    while (!gotDone && cnt < 2000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (cnt == 1) start = 1'b0;
      if (poke && cnt == 3) begin
        start = 1'b1; opCode = MV; lenCode = 8'h05; dstAddr = 24'h0; srcAddr = 24'h10;
      end
      if (poke && cnt == 4) start = 1'b0;
      rd += int'(memRd); wr += int'(memWr);
      if (done) gotDone = 1;
      if (poke && done) start = 1'b1;
    end
    chk({tag, " R9 done cycle"}, cnt, expCyc);
    chk({tag, " R6 reads"}, rd, expRd);
    chk({tag, " R4 writes"}, wr, expWr);
    chk({tag, " R5 condCode"}, int'(condCode), int'(expCc));
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 done low after pulse"}, int'(done), 0);
    chk({tag, " R8 idle after done"}, int'(busy), 0);
    diffs = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== refMem[i]) diffs++;
    chk({tag, " R2 memory image"}, diffs, 0);
  endtask

  task automatic setByte(input int a, input logic [7:0] v);
    mem[a % MSZ] = v; refMem[a % MSZ] = v;
  endtask

  initial begin
    int a1, a2, len, sel;
    logic [7:0] op;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'($urandom); refMem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 memRd/memWr", int'(memRd) + int'(memWr), 0);
    chk("R1 condCode", int'(condCode), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    runOp(MV, 8'h0D, 100, 300, 0, "R3 move 14");
    runOp(MV, 8'h00, 500, 600, 0, "R3 move 1");
    runOp(MV, 8'hFF, 0, 700, 0, "R3 move 256");
    runOp(CP, 8'hFF, 0, 700, 0, "R5 cmp equal 256");
    for (int i = 0; i < 8; i++) setByte(40 + i, 8'h33);
    for (int i = 0; i < 8; i++) setByte(60 + i, 8'h33);
    setByte(40, 8'h10); setByte(60, 8'h20);
    runOp(CP, 7, 40, 60, 0, "R6 cmp lower at 0");
    setByte(40, 8'h20); setByte(44, 8'h80); setByte(64, 8'h7F);
    runOp(CP, 7, 40, 60, 0, "R5 cmp unsigned higher");
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 cc held", int'(condCode), 2);
    runOp(MV, 3, 200, 220, 0, "R10 move clears cc");
    runOp(MV, 9, 801, 800, 0, "R7 overlap");
    for (int i = 1; i < 10; i++) chk("R7 propagated byte", int'(mem[801 + i]), int'(mem[800]));
    runOp(8'h47, 20, 10, 30, 0, "R11 other opcode");
    runOp(MV, 12, 900, 400, 1, "R8 start while busy");
    runOp(CP, 12, 900, 400, 1, "R8 cmp start while busy");

    for (int t = 0; t < 30; t++) begin
      sel = int'($urandom % 8);
      op = (sel == 0) ? 8'h58 : (sel < 4 ? MV : CP);
      len = ($urandom % 6 == 0) ? 255 : int'($urandom % 48);
      a1 = int'($urandom % MSZ); a2 = int'($urandom % MSZ);
      if (op == CP && ($urandom % 2 == 1)) begin
        for (int i = 0; i <= len; i++) setByte(a1 + i, refMem[addrOf(a2, i)]);
        if ($urandom % 2 == 1) setByte(a1 + int'($urandom % (len + 1)), 8'($urandom));
      end
      runOp(op, len, a1, a2, 0, "R2 random");
    end
    finish();
  end
endmodule